// File: doc/BRIEF.md
# Serial Interrupt Bus Peripheral Agent

This block is the peripheral end of a single-wire, open-drain serialized interrupt bus. A host controller starts each bus cycle with a low Start Frame. A fixed train of three-clock data frames follows, and the cycle ends with a short low Stop Frame. The agent counts frames from the end of the Start Frame and reports its local interrupt level in the frame that matches its programmed slot number. Each data frame has three phases: sample, recovery and turnaround. In the sample phase the agent pulls the line low when its interrupt is inactive and leaves it floating when the interrupt is active. It then drives the line high for the recovery phase and lets go in the turnaround phase.

The width of the Stop Frame selects the mode for the gap before the next cycle. A two-clock low selects Quiet mode and a three-clock low selects Continuous mode. In Continuous mode only the host may start a cycle. In Quiet mode the agent may start a cycle itself when its interrupt level differs from the level it last reported. It does so by pulling the line low for one clock, and the host then completes the Start Frame. The bus pad, the pull-up and the decoding of slots into vectors on the host side sit outside this block.

Top module: `serial_irq_agent`

## Requirements
- R1: While `rst_n` is low, `line_oe` is 0. After reset the agent is in Continuous mode, so it never drives the line before a host-started cycle, even when `irq_lvl` is 1.
- R2: Let edge K be the first rising edge that samples the line high after a Start Frame low. Frame f (counting from 0) occupies clocks K+3f, K+3f+1 and K+3f+2, in the order sample, recovery, turnaround. There are DATA_FRAMES (default 17) frames.
- R3: In the sample clock of frame `slot_num`, the agent drives 0 (`line_oe`=1, `line_o`=0) when `irq_lvl` is 0 and leaves `line_oe`=0 when `irq_lvl` is 1.
- R4: In the recovery clock of its slot the agent drives 1 (`line_oe`=1, `line_o`=1). In the turnaround clock, and in every other frame, `line_oe`=0.
- R5: Slot numbers 0 to DATA_FRAMES-1 are served, which includes slot 14. A `slot_num` of DATA_FRAMES or more is never driven.
- R6: After the data frames, a low of exactly 2 clocks selects Quiet mode and a low of exactly 3 clocks selects Continuous mode. Single-clock lows at that point are skipped. A low of 4 or more clocks ends the cycle and leaves the mode unchanged.
- R7: In Continuous mode the agent never drives the line outside its slot.
- R8: In Quiet mode the agent starts a cycle only when `irq_lvl` differs from the level it reported in its last slot. It pulls the line low for exactly one clock and then releases it.
- R9: Let E be the edge that first samples the line high after the Stop Frame. A self-start drive begins no earlier than edge E+2.
- R10: In Quiet mode, a Start Frame from the host is followed exactly as in Continuous mode, and a pending self-start yields to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| line_i | input | 1 | Sampled level of the shared interrupt line |
| line_o | output | 1 | Level driven onto the line when enabled |
| line_oe | output | 1 | Output enable for the line driver |
| irq_lvl | input | 1 | Local interrupt level, 1 = active |
| slot_num | input | SLOT_W | Frame index in which the interrupt is reported |

## Verification
The assertions assume a well-behaved host. The host releases the line at the end of each Start Frame and Stop Frame, and it never pulls the line low during the agent's recovery clock. They also assume that `irq_lvl` and `slot_num` are synchronous and do not change inside the agent's slot. The bench models the line as a wired-AND of the agent and a host driver. It moves every input only on falling edges, and it changes the slot and interrupt level only on the first clock of a Start Frame. This keeps a level change during idle from racing against a host start.

// File: rtl/sia_pkg.sv
package sia_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SELF   = 3'd1,
    ST_START  = 3'd2,
    ST_FRAMES = 3'd3,
    ST_STOP   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_RECOVER = 2'd1,
    PH_TURN    = 2'd2
  } phase_e;

  typedef enum logic {
    MODE_CONT  = 1'b0,
    MODE_QUIET = 1'b1
  } mode_e;

endpackage

// File: rtl/sia_rst_sync.sv
module sia_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] shreg_q;
  logic [STAGES-1:0] shreg_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb shreg_d = {shreg_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb shreg_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= shreg_d;
  end

  assign rst_sync_n = shreg_q[TOP];
endmodule

// File: rtl/sia_low_meter.sv
module sia_low_meter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic [CNT_W-1:0] low_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;

  // Run length of consecutive low samples, saturating; cleared on a high sample.
  always_comb begin
    cnt_d = low_cnt;
    if (line_i)                 cnt_d = '0;
    else if (low_cnt != CNT_MAX) cnt_d = low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else        low_cnt <= cnt_d;
  end
endmodule

// File: rtl/sia_sequencer.sv
module sia_sequencer
  import sia_pkg::*;
#(
  parameter int DATA_FRAMES = 17,
  parameter int MIN_GAP     = 2,
  parameter int CNT_W       = 3,
  parameter int FR_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic             pending,
  output seq_state_e       state_q,
  output phase_e           phase_q,
  output logic [FR_W-1:0]  frame_q,
  output mode_e            mode_q
);
  localparam int GAP_W = (MIN_GAP > 1) ? $clog2(MIN_GAP + 1) : 1;
  localparam logic [FR_W-1:0]  LAST_FR  = FR_W'(DATA_FRAMES - 1);
  localparam logic [GAP_W-1:0] GAP_REQ  = GAP_W'(MIN_GAP);
  localparam logic [CNT_W-1:0] W_QUIET  = CNT_W'(2);
  localparam logic [CNT_W-1:0] W_CONT   = CNT_W'(3);

  seq_state_e       state_d;
  phase_e           phase_d;
  logic [FR_W-1:0]  frame_d;
  mode_e            mode_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  logic gap_ok;
  logic stop_end;

  assign gap_ok   = (gap_q >= GAP_REQ);
  // A high sample closing a low run of two or more clocks.
  assign stop_end = line_i && (low_cnt >= W_QUIET);

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    frame_d = frame_q;
    mode_d  = mode_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!gap_ok) gap_d = gap_q + 1'b1;
        if (!line_i) begin
          state_d = ST_START;
        end else if ((mode_q == MODE_QUIET) && pending && gap_ok) begin
          state_d = ST_SELF;
        end
      end
      ST_SELF: begin
        state_d = ST_START;
      end
      ST_START: begin
        if (line_i) begin
          state_d = ST_FRAMES;
          frame_d = '0;
          phase_d = PH_SAMPLE;
        end
      end
      ST_FRAMES: begin
        unique case (phase_q)
          PH_SAMPLE:  phase_d = PH_RECOVER;
          PH_RECOVER: phase_d = PH_TURN;
          default: begin
            phase_d = PH_SAMPLE;
            if (frame_q == LAST_FR) state_d = ST_STOP;
            else                    frame_d = frame_q + 1'b1;
          end
        endcase
      end
      ST_STOP: begin
        if (stop_end) begin
          if (low_cnt == W_QUIET)     mode_d = MODE_QUIET;
          else if (low_cnt == W_CONT) mode_d = MODE_CONT;
          state_d = ST_IDLE;
          gap_d   = GAP_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_SAMPLE;
      frame_q <= '0;
      mode_q  <= MODE_CONT;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      frame_q <= frame_d;
      mode_q  <= mode_d;
      gap_q   <= gap_d;
    end
  end
endmodule

// File: rtl/sia_slot_driver.sv
module sia_slot_driver
  import sia_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int FR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_q,
  input  phase_e            phase_q,
  input  logic [FR_W-1:0]   frame_q,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic              irq_lvl,
  output logic              line_o,
  output logic              line_oe,
  output logic              pending
);
  logic slot_hit;
  logic rep_en;
  logic rep_q;

  assign slot_hit = (state_q == ST_FRAMES) && (32'(frame_q) == 32'(slot_num));
  assign rep_en   = slot_hit && (phase_q == PH_SAMPLE);

  always_comb begin
    line_oe = 1'b0;
    line_o  = 1'b1;
    if (state_q == ST_SELF) begin
      line_oe = 1'b1;
      line_o  = 1'b0;
    end else if (slot_hit) begin
      unique case (phase_q)
        PH_SAMPLE: begin
          line_oe = !irq_lvl;
          line_o  = 1'b0;
        end
        PH_RECOVER: begin
          line_oe = 1'b1;
          line_o  = 1'b1;
        end
        default: line_oe = 1'b0;
      endcase
    end
  end

  // Level last put on the bus, captured as the sample clock closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rep_q <= 1'b0;
    else if (rep_en) rep_q <= irq_lvl;
  end

  assign pending = (irq_lvl != rep_q);
endmodule

// File: rtl/serial_irq_agent.sv
module serial_irq_agent
  import sia_pkg::*;
#(
  parameter int DATA_FRAMES = 17,
  parameter int SLOT_W      = 5,
  parameter int MIN_GAP     = 2,
  parameter int LOW_CNT_W   = 3,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              line_o,
  output logic              line_oe,
  input  logic              irq_lvl,
  input  logic [SLOT_W-1:0] slot_num
);
  localparam int FR_W = (DATA_FRAMES > 1) ? $clog2(DATA_FRAMES) : 1;

  logic                 core_rst_n;
  logic [LOW_CNT_W-1:0] low_cnt;
  logic                 pending;
  seq_state_e           seq_state;
  phase_e               seq_phase;
  logic [FR_W-1:0]      seq_frame;
  mode_e                seq_mode;

  sia_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  sia_low_meter #(.CNT_W(LOW_CNT_W)) u_meter (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .line_i  (line_i),
    .low_cnt (low_cnt)
  );

  sia_sequencer #(
    .DATA_FRAMES (DATA_FRAMES),
    .MIN_GAP     (MIN_GAP),
    .CNT_W       (LOW_CNT_W),
    .FR_W        (FR_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .line_i  (line_i),
    .low_cnt (low_cnt),
    .pending (pending),
    .state_q (seq_state),
    .phase_q (seq_phase),
    .frame_q (seq_frame),
    .mode_q  (seq_mode)
  );

  sia_slot_driver #(
    .SLOT_W (SLOT_W),
    .FR_W   (FR_W)
  ) u_drv (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .state_q  (seq_state),
    .phase_q  (seq_phase),
    .frame_q  (seq_frame),
    .slot_num (slot_num),
    .irq_lvl  (irq_lvl),
    .line_o   (line_o),
    .line_oe  (line_oe),
    .pending  (pending)
  );
endmodule

// File: rtl/sia_checks.sv
module sia_checks
  import sia_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       line_i,
  input logic       line_o,
  input logic       line_oe,
  input seq_state_e state,
  input mode_e      mode
);
  logic drv_low;
  assign drv_low = line_oe && !line_o;

  // R1: the first edge after reset release still finds the core idle and in Continuous mode
  a_r1_cont_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (mode == MODE_CONT) && !line_oe);

  // R4: a low drive inside the frames is followed by a one-clock high drive
  a_r4_recover_high: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_low && state == ST_FRAMES) |=> (line_oe && line_o));

  // R5: the line is driven only in data frames or during a self-start
  a_r5_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> (state == ST_SELF || state == ST_FRAMES));

  // R6: a stop low of exactly two samples yields Quiet mode
  a_r6_two_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && line_i && !$past(line_i) && !$past(line_i, 2) && $past(line_i, 3))
      |=> (mode == MODE_QUIET));

  // R7: a self-start happens only in Quiet mode
  a_r7_self_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SELF) |-> (mode == MODE_QUIET));

  // R8: the agent never pulls the line low for two clocks in a row
  a_r8_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    drv_low |=> !drv_low);

  // R9: a self-start is preceded by two high samples
  a_r9_gap_before_self: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SELF) |-> ($past(line_i) && $past(line_i, 2)));
endmodule

bind serial_irq_agent sia_checks u_sia_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .line_i  (line_i),
  .line_o  (line_o),
  .line_oe (line_oe),
  .state   (seq_state),
  .mode    (seq_mode)
);

// File: tb/serial_irq_agent_test.sv
`timescale 1ns/1ps
module serial_irq_agent_test;
  localparam int DF = 17;

  logic       clk;
  logic       rst_n;
  logic       irq_lvl;
  logic [4:0] slot_num;
  logic       host_low;
  logic       line_o;
  logic       line_oe;
  logic       line_i;

  int checks;
  int errors;

  // Wired-AND line with a pull-up.
  assign line_i = !((line_oe && !line_o) || host_low);

  serial_irq_agent #(.DATA_FRAMES(DF), .SLOT_W(5)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_i),
    .line_o   (line_o),
    .line_oe  (line_oe),
    .irq_lvl  (irq_lvl),
    .slot_num (slot_num)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic watch_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!line_oe, req, "no drive while idle", line_oe, 0);
    end
  endtask

  // One host cycle: start low, data frames with per-phase checks, optional
  // single-clock lows, then a stop low of stop_len clocks.
  task automatic run_cycle(input int slot, input bit lvl, input int start_len,
                           input int stop_len, input int extra);
    for (int i = 0; i < start_len; i++) begin
      @(negedge clk);
      host_low = 1'b1;
      if (i == 0) begin
        slot_num = 5'(slot);
        irq_lvl  = lvl;
      end
    end
    @(negedge clk);
    host_low = 1'b0;
    for (int f = 0; f < DF; f++) begin
      for (int p = 0; p < 3; p++) begin
        bit eoe, eo;
        @(negedge clk);
        eoe = 1'b0;
        eo  = 1'b1;
        if (f == slot) begin
          if (p == 0) begin eoe = !lvl; eo = 1'b0; end
          else if (p == 1) begin eoe = 1'b1; eo = 1'b1; end
        end
        if (slot >= DF)
          chk(line_oe == 1'b0, "R5", "out-of-range slot drive", line_oe, 0);
        else if (p == 0)
          chk(line_oe == eoe && (!eoe || line_o == eo), "R3", "sample phase oe",
              line_oe, eoe);
        else
          chk(line_oe == eoe && (!eoe || line_o == eo), "R4", "recovery/turnaround oe",
              line_oe, eoe);
        if (f != slot)
          chk(!line_oe, "R2", "drive outside own frame", line_oe, 0);
      end
    end
    for (int k = 0; k < extra; k++) begin
      @(negedge clk); host_low = 1'b1;
      @(negedge clk); host_low = 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < stop_len; i++) begin
      @(negedge clk);
      host_low = 1'b1;
    end
    @(negedge clk);
    host_low = 1'b0;
  endtask

  // Called at the negedge where the stop low was released.
  task automatic check_gap(input bit exp_self);
    @(negedge clk);
    chk(!line_oe, "R9", "drive one clock after stop", line_oe, 0);
    @(negedge clk);
    chk(!line_oe, "R9", "drive two clocks after stop", line_oe, 0);
    @(negedge clk);
    if (exp_self)
      chk(line_oe && !line_o, "R8", "self-start low expected", line_oe, 1);
    else
      chk(!line_oe, "R8", "no self-start without level change", line_oe, 0);
    @(negedge clk);
    chk(!line_oe, "R8", "self-start lasts one clock", line_oe, 0);
    if (exp_self) host_low = 1'b1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!line_oe, "R1", "released during reset", line_oe, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    irq_lvl = 1'b1;
    watch_idle(12, "R1");
  endtask

  task automatic t_slot_report;
    run_cycle(5, 1'b0, 4, 3, 0);
    watch_idle(6, "R7");
    irq_lvl = 1'b1;
    watch_idle(10, "R7");
  endtask

  task automatic t_slot14_quiet;
    run_cycle(14, 1'b1, 6, 2, 0);
    check_gap(1'b0);
    watch_idle(4, "R8");
  endtask

  task automatic t_level_change;
    @(negedge clk);
    irq_lvl = 1'b0;
    @(negedge clk);
    chk(line_oe && !line_o, "R8", "self-start after level change", line_oe, 1);
    @(negedge clk);
    chk(!line_oe, "R8", "self-start released", line_oe, 0);
    host_low = 1'b1;
    run_cycle(14, 1'b0, 3, 2, 0);
  endtask

  task automatic t_gap_and_quiet_host;
    run_cycle(20, 1'b1, 4, 2, 0);
    check_gap(1'b1);
    // R10: host completes the start; agent follows the cycle
    run_cycle(3, 1'b1, 3, 2, 0);
    check_gap(1'b0);
    run_cycle(3, 1'b1, 4, 2, 0);
    check_gap(1'b0);
  endtask

  task automatic t_single_lows;
    run_cycle(20, 1'b0, 4, 2, 2);
    check_gap(1'b1);
    run_cycle(3, 1'b0, 3, 3, 0);
    watch_idle(3, "R6");
    irq_lvl = 1'b1;
    watch_idle(10, "R7");
  endtask

  task automatic t_long_stop;
    run_cycle(20, 1'b1, 4, 4, 0);
    watch_idle(10, "R6");
    run_cycle(20, 1'b1, 4, 2, 0);
    check_gap(1'b1);
    run_cycle(20, 1'b1, 3, 4, 0);
    check_gap(1'b1);
    run_cycle(7, 1'b1, 3, 3, 0);
    watch_idle(8, "R7");
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    rst_n    = 1'b0;
    host_low = 1'b0;
    irq_lvl  = 1'b0;
    slot_num = 5'd5;
    t_reset();
    t_slot_report();
    t_slot14_quiet();
    t_level_change();
    t_gap_and_quiet_host();
    t_single_lows();
    t_long_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule